// File: doc/BRIEF.md
# Dual-Port RAM Access Arbiter

This block shares one single-ported RAM between two masters. The first is a host processor whose bus cycles always take four clocks. The second is an embedded protocol controller that issues single-clock read and write requests. The RAM array is never accessed by both masters in the same clock.

Each accepted host cycle gets exactly one array slot, at a fixed clock inside the cycle. The other three clocks of the cycle belong to the controller. A controller request that lands on the host slot is held off for that one clock and is served on the next clock.

The host latches its address, write data and byte enables when its start strobe is seen. Its acknowledge, together with any read data, appears in the fourth clock of the cycle. Controller read data returns one clock after the grant.

Top module: `dpram_slot_arbiter`

## Requirements
- R1: While `rst_n` is low and in the first clock after it rises, `host_ack` and `ctl_rvalid` are 0 and `ctl_rdy` is 1. The host cycle tracker is idle at that point.
- R2: A `host_start` sampled while the tracker is idle begins a host cycle. `host_ack` is high in exactly one clock, three clocks after the start clock. In that clock, for a read, `host_rdata` holds the addressed word.
- R3: A `host_start` sampled while a host cycle is in progress is ignored. It causes no array access and no acknowledge.
- R4: A host write takes effect in the array during the host slot, two clocks after the start clock. A later read from either port returns the most recently written data.
- R5: `ctl_rdy` is low only in the host slot clock. It is therefore never low in two consecutive clocks, so a waiting controller request is stalled for at most one clock.
- R6: A controller request is granted in a clock where `ctl_req` and `ctl_rdy` are both high. A granted read raises `ctl_rvalid` in the next clock, with the addressed word on `ctl_rdata`. A granted write updates the array at the end of the grant clock.
- R7: Host and controller are never granted the array in the same clock. With back-to-back host cycles and a controller that requests every clock, the controller is granted 12 of every 16 clocks and the host is acknowledged 4 times.
- R8: The byte enables act on both ports for writes. Bit 0 enables data bits 7:0 and bit 1 enables bits 15:8. A disabled byte keeps its old value.
- R9: Reset does not change the RAM contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_start | input | 1 | Host cycle start strobe, one clock |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | 8 | Host word address |
| host_be | input | 2 | Host byte enables |
| host_wdata | input | 16 | Host write data |
| host_ack | output | 1 | Host cycle acknowledge |
| host_rdata | output | 16 | Host read data, valid with acknowledge |
| ctl_req | input | 1 | Controller access request |
| ctl_we | input | 1 | Controller write (1) or read (0) |
| ctl_addr | input | 8 | Controller word address |
| ctl_be | input | 2 | Controller byte enables |
| ctl_wdata | input | 16 | Controller write data |
| ctl_rdy | output | 1 | Controller may be granted this clock |
| ctl_rvalid | output | 1 | Controller read data valid |
| ctl_rdata | output | 16 | Controller read data |

## Verification
The assertions check on every clock that the two masters are never granted together and that `ctl_rdy` drops only in the host slot and never twice in a row. They also check that an acknowledge always follows an accepted start by three clocks and that controller read-valid only follows a granted read. Whether the right data comes back, whether byte lanes merge correctly, whether ignored strobes leave the RAM untouched and whether the contents survive reset all depend on stored values. Only the bench's reference memory and its scenarios can show those, including the back-to-back run that counts grants and acknowledges.

// File: rtl/dpra_pkg.sv
`timescale 1ns/1ps
package dpra_pkg;

    // Host cycle phases; the array slot sits in PH_SLOT, the acknowledge in PH_ACK.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WAIT = 2'd1,
        PH_SLOT = 2'd2,
        PH_ACK  = 2'd3
    } host_phase_e;

endpackage

// File: rtl/dpra_host_trk.sv
`timescale 1ns/1ps
module dpra_host_trk
    import dpra_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W/8-1:0] be_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              slot_o,
    output logic              ack_o,
    output logic              busy_o,
    output logic              we_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W/8-1:0] be_o,
    output logic [DATA_W-1:0] wdata_o
);

    localparam int unsigned BE_W = DATA_W / 8;

    typedef struct packed {
        host_phase_e       phase;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [BE_W-1:0]   be;
        logic [DATA_W-1:0] wdata;
    } trk_t;

    trk_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    s_d.phase = PH_WAIT;
                    s_d.we    = we_i;
                    s_d.addr  = addr_i;
                    s_d.be    = be_i;
                    s_d.wdata = wdata_i;
                end
            end
            PH_WAIT: s_d.phase = PH_SLOT;
            PH_SLOT: s_d.phase = PH_ACK;
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign slot_o  = (s_q.phase == PH_SLOT);
    assign ack_o   = (s_q.phase == PH_ACK);
    assign busy_o  = (s_q.phase != PH_IDLE);
    assign we_o    = s_q.we;
    assign addr_o  = s_q.addr;
    assign be_o    = s_q.be;
    assign wdata_o = s_q.wdata;

endmodule

// File: rtl/dpra_ctl_port.sv
`timescale 1ns/1ps
module dpra_ctl_port (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic we_i,
    input  logic host_slot_i,
    output logic rdy_o,
    output logic gnt_o,
    output logic rvalid_o
);

    typedef struct packed {
        logic rvalid;
    } port_t;

    port_t p_d, p_q;

    always_comb begin
        p_d        = p_q;
        p_d.rvalid = req_i && !host_slot_i && !we_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign rdy_o    = !host_slot_i;
    assign gnt_o    = req_i && !host_slot_i;
    assign rvalid_o = p_q.rvalid;

endmodule

// File: rtl/dpra_mem.sv
`timescale 1ns/1ps
module dpra_mem #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W/8-1:0] be_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int unsigned BE_W  = DATA_W / 8;
    localparam int unsigned DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_t;

    logic [DATA_W-1:0] arr [DEPTH];
    logic [DATA_W-1:0] lane_mask;
    rd_t               r_d, r_q;

    for (genvar g = 0; g < BE_W; g++) begin : g_lane
        assign lane_mask[g*8 +: 8] = {8{be_i[g]}};
    end

    // Array contents carry no reset so they survive a block reset.
    always_ff @(posedge clk) begin
        if (en_i && we_i)
            arr[addr_i] <= (arr[addr_i] & ~lane_mask) | (wdata_i & lane_mask);
    end

    always_comb begin
        r_d = r_q;
        if (en_i && !we_i) r_d.rdata = arr[addr_i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rdata_o = r_q.rdata;

endmodule

// File: rtl/dpram_slot_arbiter.sv
`timescale 1ns/1ps
module dpram_slot_arbiter #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_start,
    input  logic                host_we,
    input  logic [ADDR_W-1:0]   host_addr,
    input  logic [DATA_W/8-1:0] host_be,
    input  logic [DATA_W-1:0]   host_wdata,
    output logic                host_ack,
    output logic [DATA_W-1:0]   host_rdata,
    input  logic                ctl_req,
    input  logic                ctl_we,
    input  logic [ADDR_W-1:0]   ctl_addr,
    input  logic [DATA_W/8-1:0] ctl_be,
    input  logic [DATA_W-1:0]   ctl_wdata,
    output logic                ctl_rdy,
    output logic                ctl_rvalid,
    output logic [DATA_W-1:0]   ctl_rdata
);

    localparam int unsigned BE_W = DATA_W / 8;

    logic              host_slot, host_busy, ctl_gnt;
    logic              h_we;
    logic [ADDR_W-1:0] h_addr;
    logic [BE_W-1:0]   h_be;
    logic [DATA_W-1:0] h_wdata;

    logic              m_en, m_we;
    logic [ADDR_W-1:0] m_addr;
    logic [BE_W-1:0]   m_be;
    logic [DATA_W-1:0] m_wdata, m_rdata;

    dpra_host_trk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_trk (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (host_start),
        .we_i    (host_we),
        .addr_i  (host_addr),
        .be_i    (host_be),
        .wdata_i (host_wdata),
        .slot_o  (host_slot),
        .ack_o   (host_ack),
        .busy_o  (host_busy),
        .we_o    (h_we),
        .addr_o  (h_addr),
        .be_o    (h_be),
        .wdata_o (h_wdata)
    );

    dpra_ctl_port u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (ctl_req),
        .we_i        (ctl_we),
        .host_slot_i (host_slot),
        .rdy_o       (ctl_rdy),
        .gnt_o       (ctl_gnt),
        .rvalid_o    (ctl_rvalid)
    );

    // Array port select: the host slot always wins, otherwise the controller grant.
    always_comb begin
        m_en    = host_slot || ctl_gnt;
        m_we    = host_slot ? h_we    : ctl_we;
        m_addr  = host_slot ? h_addr  : ctl_addr;
        m_be    = host_slot ? h_be    : ctl_be;
        m_wdata = host_slot ? h_wdata : ctl_wdata;
    end

    dpra_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (m_en),
        .we_i    (m_we),
        .addr_i  (m_addr),
        .be_i    (m_be),
        .wdata_i (m_wdata),
        .rdata_o (m_rdata)
    );

    // One read register serves both ports; their read clocks never coincide.
    assign host_rdata = m_rdata;
    assign ctl_rdata  = m_rdata;

endmodule

// File: rtl/dpra_chk.sv
`timescale 1ns/1ps
module dpra_chk (
    input logic clk,
    input logic rst_n,
    input logic host_start,
    input logic host_busy,
    input logic host_slot,
    input logic host_ack,
    input logic ctl_req,
    input logic ctl_we,
    input logic ctl_rdy,
    input logic ctl_gnt,
    input logic ctl_rvalid
);

    // R7
    both_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_slot && ctl_gnt));

    // R5
    stall_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_req && !ctl_rdy) |=> ctl_rdy);

    // R5
    rdy_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_rdy |-> host_slot);

    // R2
    ack_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |-> $past(host_start && !host_busy, 3));

    // R3
    one_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_slot |=> !host_slot);

    // R6
    rvalid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rvalid |-> $past(ctl_req && ctl_rdy && !ctl_we));

endmodule

bind dpram_slot_arbiter dpra_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_start (host_start),
    .host_busy  (host_busy),
    .host_slot  (host_slot),
    .host_ack   (host_ack),
    .ctl_req    (ctl_req),
    .ctl_we     (ctl_we),
    .ctl_rdy    (ctl_rdy),
    .ctl_gnt    (ctl_gnt),
    .ctl_rvalid (ctl_rvalid)
);

// File: tb/dpram_slot_arbiter_test.sv
`timescale 1ns/1ps
module dpram_slot_arbiter_test;

    localparam int AW = 8;
    localparam int DW = 16;
    localparam int BW = 2;
    localparam int DEPTH = 256;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          host_start = 0, host_we = 0;
    logic [AW-1:0] host_addr = '0;
    logic [BW-1:0] host_be = '0;
    logic [DW-1:0] host_wdata = '0;
    logic          host_ack;
    logic [DW-1:0] host_rdata;
    logic          ctl_req = 0, ctl_we = 0;
    logic [AW-1:0] ctl_addr = '0;
    logic [BW-1:0] ctl_be = '0;
    logic [DW-1:0] ctl_wdata = '0;
    logic          ctl_rdy, ctl_rvalid;
    logic [DW-1:0] ctl_rdata;

    dpram_slot_arbiter uut (.*);

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string tag = "R1";

    logic [DW-1:0] ref_mem [DEPTH];
    int            m_phase = 0;
    logic          m_we;
    logic [AW-1:0] m_addr;
    logic [BW-1:0] m_be;
    logic [DW-1:0] m_wd;
    logic          e_ack = 0, e_hrd = 0, e_rv = 0;
    logic [DW-1:0] e_hd, e_cd;
    bit            stall_prev = 0;
    bit            last_stall = 0;
    int            gnt_cnt = 0, ack_cnt = 0;

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] o, input logic [DW-1:0] n,
                                            input logic [BW-1:0] be);
        logic [DW-1:0] r = o;
        for (int i = 0; i < BW; i++) if (be[i]) r[i*8 +: 8] = n[i*8 +: 8];
        return r;
    endfunction

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Called just after a falling edge: check outputs, drive inputs, advance model.
    task automatic step(input bit hs, input bit hwe, input logic [AW-1:0] ha, input logic [BW-1:0] hbe,
                        input logic [DW-1:0] hwd, input bit cr, input bit cwe, input logic [AW-1:0] ca,
                        input logic [BW-1:0] cbe, input logic [DW-1:0] cwd);
        bit rdy_exp;
        rdy_exp = (m_phase != 2);
        chk(host_ack === e_ack, "host_ack", 32'(host_ack), 32'(e_ack));
        if (host_ack === 1'b1) ack_cnt++;
        if (e_ack && e_hrd) chk(host_rdata === e_hd, "host_rdata", 32'(host_rdata), 32'(e_hd));
        chk(ctl_rvalid === e_rv, "ctl_rvalid", 32'(ctl_rvalid), 32'(e_rv));
        if (e_rv) chk(ctl_rdata === e_cd, "ctl_rdata", 32'(ctl_rdata), 32'(e_cd));
        // R5: ready drops only in the slot clock
        chk(ctl_rdy === rdy_exp, "R5 ctl_rdy", 32'(ctl_rdy), 32'(rdy_exp));
        // R5: never two stalled clocks in a row
        if (stall_prev) chk(ctl_rdy === 1'b1, "R5 second stall", 32'(ctl_rdy), 32'd1);
        if (cr && ctl_rdy === 1'b1) gnt_cnt++;
        last_stall = cr && (ctl_rdy !== 1'b1);
        stall_prev = last_stall;

        host_start = hs; host_we = hwe; host_addr = ha; host_be = hbe; host_wdata = hwd;
        ctl_req = cr; ctl_we = cwe; ctl_addr = ca; ctl_be = cbe; ctl_wdata = cwd;

        e_ack = 0; e_rv = 0;
        case (m_phase)
            0: if (hs) begin
                   m_phase = 1; m_we = hwe; m_addr = ha; m_be = hbe; m_wd = hwd;
               end
            1: m_phase = 2;
            2: begin
                   e_ack = 1; e_hrd = !m_we;
                   if (m_we) ref_mem[m_addr] = merge(ref_mem[m_addr], m_wd, m_be);
                   else      e_hd = ref_mem[m_addr];
                   m_phase = 3;
               end
            default: m_phase = 0;
        endcase
        if (cr && rdy_exp) begin
            if (cwe) ref_mem[ca] = merge(ref_mem[ca], cwd, cbe);
            else begin e_rv = 1; e_cd = ref_mem[ca]; end
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, '0, '0, '0, 0, 0, '0, '0, '0);
    endtask

    task automatic do_reset();
        rst_n = 0;
        host_start = 0; ctl_req = 0;
        @(negedge clk);
        @(negedge clk);
        tag = "R1";
        chk(host_ack === 1'b0, "reset host_ack", 32'(host_ack), 32'd0);
        chk(ctl_rvalid === 1'b0, "reset ctl_rvalid", 32'(ctl_rvalid), 32'd0);
        chk(ctl_rdy === 1'b1, "reset ctl_rdy", 32'(ctl_rdy), 32'd1);
        m_phase = 0; e_ack = 0; e_rv = 0; stall_prev = 0; last_stall = 0;
        rst_n = 1;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] ra, ca;
        logic [DW-1:0] rd;
        bit hs, cr, cwe;
        logic [BW-1:0] cbe;
        logic [DW-1:0] cwd;
        void'($urandom(32'h5eed_1234));
        @(negedge clk);
        do_reset();
        tag = "R1";
        idle(1);

        // R6: fill every word through the controller port
        tag = "R6";
        for (int a = 0; a < DEPTH; a++)
            step(0, 0, '0, '0, '0, 1, 1, AW'(a), 2'b11, DW'(a * 16'h0101 ^ 16'h5a3c));
        idle(2);

        // R2 / R4: host write then host read of the same word
        tag = "R4";
        step(1, 1, 8'h21, 2'b11, 16'hbeef, 0, 0, '0, '0, '0);
        idle(3);
        tag = "R2";
        step(1, 0, 8'h21, 2'b00, 16'h0, 0, 0, '0, '0, '0);
        idle(4);

        // R8: partial writes on both ports, read back through the other port
        tag = "R8";
        step(1, 1, 8'h05, 2'b01, 16'haaaa, 0, 0, '0, '0, '0);
        idle(3);
        step(0, 0, '0, '0, '0, 1, 0, 8'h05, '0, '0);
        step(0, 0, '0, '0, '0, 1, 1, 8'h06, 2'b10, 16'h7755);
        step(1, 0, 8'h06, 2'b00, 16'h0, 0, 0, '0, '0, '0);
        idle(4);

        // R3: a strobe during a busy cycle is ignored
        tag = "R3";
        step(1, 1, 8'h09, 2'b11, 16'h1234, 0, 0, '0, '0, '0);
        step(1, 1, 8'h0a, 2'b11, 16'hdead, 0, 0, '0, '0, '0);
        step(1, 1, 8'h0a, 2'b11, 16'hdead, 0, 0, '0, '0, '0);
        idle(2);
        step(0, 0, '0, '0, '0, 1, 0, 8'h0a, '0, '0);
        step(0, 0, '0, '0, '0, 1, 0, 8'h09, '0, '0);
        idle(1);
        chk(ref_mem[8'h0a] === DW'(8'h0a * 16'h0101 ^ 16'h5a3c), "R3 ignored word",
            32'(ref_mem[8'h0a]), 32'(DW'(8'h0a * 16'h0101 ^ 16'h5a3c)));

        // R7: back-to-back host cycles with a controller requesting every clock
        tag = "R7";
        gnt_cnt = 0; ack_cnt = 0;
        for (int i = 0; i < 16; i++)
            step(1, 0, AW'(i), 2'b00, '0, 1, 0, AW'(i + 40), '0, '0);
        step(0, 0, '0, '0, '0, 0, 0, '0, '0, '0);
        chk(gnt_cnt == 12, "R7 controller grants in 16 clocks", 32'(gnt_cnt), 32'd12);
        chk(ack_cnt == 4, "R7 host acks in 16 clocks", 32'(ack_cnt), 32'd4);
        idle(3);

        // R4 / R6 / R5: random mixed traffic, stalled requests held until served
        tag = "R4";
        cr = 0; cwe = 0; ca = '0; cbe = '0; cwd = '0;
        for (int i = 0; i < 3000; i++) begin
            hs = ($urandom_range(0, 3) != 0);
            if (!last_stall) begin
                cr  = ($urandom_range(0, 3) != 0);
                cwe = $urandom_range(0, 1) == 1;
                ca  = AW'($urandom_range(0, 15));
                cbe = BW'($urandom_range(0, 3));
                cwd = DW'($urandom);
            end
            ra = AW'($urandom_range(0, 15));
            rd = DW'($urandom);
            step(hs, $urandom_range(0, 1) == 1, ra, BW'($urandom_range(0, 3)), rd,
                 cr, cwe, ca, cbe, cwd);
        end
        idle(4);

        // R9: reset in the middle of traffic keeps the array contents
        step(1, 1, 8'h30, 2'b11, 16'h4242, 0, 0, '0, '0, '0);
        idle(4);
        do_reset();
        tag = "R9";
        idle(1);
        for (int a = 0; a < 16; a++)
            step(0, 0, '0, '0, '0, 1, 0, AW'(a), '0, '0);
        step(0, 0, '0, '0, '0, 1, 0, 8'h30, '0, '0);
        step(0, 0, '0, '0, '0, 1, 0, 8'h80, '0, '0);
        idle(2);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule